// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by descending a four-level radix tree of translation tables that lives in ordinary memory. A translation request carries the virtual address, a write flag and a user-mode flag. The walk begins at the table whose physical address sits on the root-base input. Each level costs one 64-bit read through a simple request/response memory port. Each fetched entry is checked for presence and for permission, and the next table is located from the physical base the entry holds.

The walker keeps the usage bits of the tree current. When an entry on a successful path still has its accessed flag clear, the walker writes the entry back with that flag set. A write request also sets the dirty flag of the final entry. A walk that meets a missing entry, or an entry that forbids the access, stops there. It then reports a fault code together with the level at which it stopped. The block serves one request at a time. No translation is cached inside it.

Top module: `pt_walk4`

## Requirements
- R1: Out of reset, req_ready is 1, and res_valid and mem_req_valid are both 0.
- R2: A walk that clears all four levels returns res_fault = 0, res_level = 4 and res_paddr = {bits 51:12 of the level-4 entry, bits 11:0 of the virtual address}.
- R3: The entry for level n (1..4) is read at {table base, index, 3'b000}. The level-1 table base is root_base[51:12], and each deeper table base is bits 51:12 of the entry above it. The index for level 1 is vaddr[47:39], for level 2 vaddr[38:30], for level 3 vaddr[29:21] and for level 4 vaddr[20:12]. The reads happen in level order, one per level reached.
- R4: An entry whose bit 0 (present) is 0 ends the walk with res_fault = 1 and res_level set to that level. No later level is read, and that entry is not written.
- R5: A write request through an entry whose bit 1 (writable) is 0 ends the walk with res_fault = 2 at that level. The entry is not written.
- R6: A user-mode request through an entry whose bit 2 (user-allowed) is 0 ends the walk with res_fault = 2 at that level. The entry is not written.
- R7: Each entry that passes its checks and has bit 5 (accessed) at 0 is written back to its own address with bit 5 set and all other bits kept. An entry whose flags already hold the required values is not written.
- R8: On a write request, the level-4 entry is written back with bit 6 (dirty) set. A read request never changes bit 6. Bit 6 is not touched at levels 1 to 3.
- R9: req_ready is 0 from the cycle after a request is accepted until the result has been given. A req_valid raised during that time is ignored.
- R10: Each accepted request yields exactly one res_valid pulse, one cycle long.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, the memory request (valid, address, write flag) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 52 | Physical address of the level-1 table (4 KB aligned) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back of an entry, 0 = entry read |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_req_wdata | output | 64 | Entry value for a write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 64 | Entry value read |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 2 | 0 none, 1 not present, 2 protection |
| res_level | output | 3 | Level at which the walk stopped (4 on success) |
| res_paddr | output | 52 | Translated physical address (0 on a fault) |

## Verification
The bench builds the walker with its default shape: four levels of 9-bit indices, a 12-bit offset, a 52-bit physical space and 64-bit entries. This places every table at a fresh 4 KB page, and the level-1 indices collide often enough that old entries get rewritten. The memory model drops mem_req_ready at random and answers reads two cycles later, which tests the held requests and the ordering of reads and write-backs. The random entry flags, and the directed paths, put a not-present or protection stop at each of the four levels. They also cover walks whose usage bits are already set, so that no write-back is due.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry flag positions the walker decodes
  localparam int unsigned FLAG_PRESENT  = 0;
  localparam int unsigned FLAG_WRITABLE = 1;
  localparam int unsigned FLAG_USER     = 2;
  localparam int unsigned FLAG_ACCESSED = 5;
  localparam int unsigned FLAG_DIRTY    = 6;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_REQ,
    WS_RD_WAIT,
    WS_CHECK,
    WS_WB_REQ,
    WS_DONE,
    WS_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    WF_NONE        = 2'd0,
    WF_NOT_PRESENT = 2'd1,
    WF_PROTECTION  = 2'd2
  } walk_fault_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int VA_W   = OFF_W + LEVELS * IDX_W,
  parameter int LCNT_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [LCNT_W-1:0] lvl,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] fields [LEVELS];

  // level 0 is the top table, taking the highest index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = vaddr[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LCNT_W'(i)) idx = fields[i];
    end
  end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PA_W  = 52,
  parameter int PPN_W = PA_W - OFF_W
) (
  input  logic [PPN_W-1:0] table_ppn,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_pa
);

  localparam int ENTRY_BYTES = 8;

  // table base page times page size, plus index times entry size
  function automatic logic [PA_W-1:0] slot_address(input logic [PPN_W-1:0] ppn,
                                                   input logic [IDX_W-1:0] i);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;
    base = {ppn, {OFF_W{1'b0}}};
    disp = PA_W'(i) * PA_W'(ENTRY_BYTES);
    return base + disp;
  endfunction

  assign entry_pa = slot_address(table_ppn, idx);

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 52,
  parameter int PPN_W   = PA_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  input  logic               is_user,
  input  logic               is_leaf,
  output logic               not_present,
  output logic               prot_viol,
  output logic               needs_wb,
  output logic [ENTRY_W-1:0] entry_upd,
  output logic [PPN_W-1:0]   next_ppn
);

  function automatic logic perm_denied(input logic [ENTRY_W-1:0] e,
                                       input logic wr, input logic usr);
    return (wr && !e[FLAG_WRITABLE]) || (usr && !e[FLAG_USER]);
  endfunction

  function automatic logic [ENTRY_W-1:0] mark_usage(input logic [ENTRY_W-1:0] e,
                                                    input logic wr, input logic leaf);
    logic [ENTRY_W-1:0] r;
    r = e;
    r[FLAG_ACCESSED] = 1'b1;
    if (wr && leaf) r[FLAG_DIRTY] = 1'b1;
    return r;
  endfunction

  assign not_present = !entry[FLAG_PRESENT];
  assign prot_viol   = perm_denied(entry, is_write, is_user);
  assign entry_upd   = mark_usage(entry, is_write, is_leaf);
  assign needs_wb    = (entry_upd != entry);
  assign next_ppn    = entry[OFF_W + PPN_W - 1:OFF_W];

endmodule

// File: rtl/pt_walk4.sv
module pt_walk4
  import ptw_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 52,
  parameter int ENTRY_W = 64,
  parameter int VA_W    = OFF_W + LEVELS * IDX_W,
  parameter int LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    root_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [ENTRY_W-1:0] mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_rdata,
  output logic               res_valid,
  output logic [1:0]         res_fault,
  output logic [LVL_W-1:0]   res_level,
  output logic [PA_W-1:0]    res_paddr
);

  localparam int PPN_W  = PA_W - OFF_W;
  localparam int LCNT_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LCNT_W-1:0] LAST_LVL = LCNT_W'(LEVELS - 1);

  walk_state_e        state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic               user_q;
  logic [PPN_W-1:0]   tbl_q;
  logic [LCNT_W-1:0]  lvl_q;
  logic [ENTRY_W-1:0] entry_q;
  walk_fault_e        fault_q;
  logic [LVL_W-1:0]   level_q;
  logic [PA_W-1:0]    paddr_q;

  logic [IDX_W-1:0]   cur_idx;
  logic [PA_W-1:0]    cur_entry_pa;
  logic               chk_not_present;
  logic               chk_prot;
  logic               chk_needs_wb;
  logic [ENTRY_W-1:0] chk_entry_upd;
  logic [PPN_W-1:0]   chk_next_ppn;
  logic               at_leaf;
  logic [LVL_W-1:0]   cur_level;

  // named internal events
  logic walk_start;
  logic rd_fire;
  logic rsp_take;
  logic wb_fire;
  logic step_fwd;
  logic fault_hit;

  ptw_index_sel #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .VA_W(VA_W), .LCNT_W(LCNT_W)
  ) u_idx (
    .vaddr(va_q), .lvl(lvl_q), .idx(cur_idx)
  );

  ptw_entry_addr #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PPN_W(PPN_W)
  ) u_addr (
    .table_ppn(tbl_q), .idx(cur_idx), .entry_pa(cur_entry_pa)
  );

  ptw_entry_check #(
    .ENTRY_W(ENTRY_W), .OFF_W(OFF_W), .PA_W(PA_W), .PPN_W(PPN_W)
  ) u_chk (
    .entry(entry_q), .is_write(wr_q), .is_user(user_q), .is_leaf(at_leaf),
    .not_present(chk_not_present), .prot_viol(chk_prot), .needs_wb(chk_needs_wb),
    .entry_upd(chk_entry_upd), .next_ppn(chk_next_ppn)
  );

  assign at_leaf   = (lvl_q == LAST_LVL);
  assign cur_level = LVL_W'(lvl_q) + LVL_W'(1);

  assign walk_start = (state_q == WS_IDLE) && req_valid;
  assign rd_fire    = (state_q == WS_RD_REQ) && mem_req_ready;
  assign rsp_take   = (state_q == WS_RD_WAIT) && mem_rsp_valid;
  assign wb_fire    = (state_q == WS_WB_REQ) && mem_req_ready;
  assign fault_hit  = (state_q == WS_CHECK) && (chk_not_present || chk_prot);
  assign step_fwd   = ((state_q == WS_CHECK) && !chk_not_present && !chk_prot && !chk_needs_wb)
                    || wb_fire;

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_RD_REQ) || (state_q == WS_WB_REQ);
  assign mem_req_write = (state_q == WS_WB_REQ);
  assign mem_req_addr  = cur_entry_pa;
  assign mem_req_wdata = (state_q == WS_WB_REQ) ? chk_entry_upd : '0;

  assign res_valid = (state_q == WS_DONE) || (state_q == WS_FAULT);
  assign res_fault = fault_q;
  assign res_level = level_q;
  assign res_paddr = paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      tbl_q   <= '0;
      lvl_q   <= '0;
      entry_q <= '0;
      fault_q <= WF_NONE;
      level_q <= '0;
      paddr_q <= '0;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (walk_start) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            user_q  <= req_user;
            tbl_q   <= root_base[PA_W-1:OFF_W];
            lvl_q   <= '0;
            state_q <= WS_RD_REQ;
          end
        end
        WS_RD_REQ:  if (rd_fire) state_q <= WS_RD_WAIT;
        WS_RD_WAIT: begin
          if (rsp_take) begin
            entry_q <= mem_rsp_rdata;
            state_q <= WS_CHECK;
          end
        end
        WS_CHECK: begin
          if (chk_not_present) begin
            fault_q <= WF_NOT_PRESENT;
            level_q <= cur_level;
            paddr_q <= '0;
            state_q <= WS_FAULT;
          end else if (chk_prot) begin
            fault_q <= WF_PROTECTION;
            level_q <= cur_level;
            paddr_q <= '0;
            state_q <= WS_FAULT;
          end else if (chk_needs_wb) begin
            state_q <= WS_WB_REQ;
          end
        end
        WS_WB_REQ: ;
        default:   state_q <= WS_IDLE;
      endcase

      if (step_fwd) begin
        if (at_leaf) begin
          fault_q <= WF_NONE;
          level_q <= cur_level;
          paddr_q <= {chk_next_ppn, va_q[OFF_W-1:0]};
          state_q <= WS_DONE;
        end else begin
          tbl_q   <= chk_next_ppn;
          lvl_q   <= lvl_q + LCNT_W'(1);
          state_q <= WS_RD_REQ;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));

  assert_entry_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_wb_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[FLAG_ACCESSED]);

  assert_wb_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> entry_q[FLAG_PRESENT]);

  assert_dirty_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !wr_q) |->
      (mem_req_wdata[FLAG_DIRTY] == entry_q[FLAG_DIRTY]));

  assert_fault_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 2'd0) |->
      (res_level >= LVL_W'(1) && res_level <= LVL_W'(LEVELS)));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'd0) |->
      (res_paddr[OFF_W-1:0] == va_q[OFF_W-1:0] && res_level == LVL_W'(LEVELS)));

endmodule

// File: tb/pt_walk4_tb.sv
module pt_walk4_tb;

  localparam int LOGN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        res_valid;
  logic [1:0]  res_fault;
  logic [2:0]  res_level;
  logic [51:0] res_paddr;

  always #5 clk = ~clk;

  pt_walk4 u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .res_valid(res_valid), .res_fault(res_fault),
    .res_level(res_level), .res_paddr(res_paddr)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [51:0]];
  logic [51:0] rd_log [LOGN];
  logic [51:0] wa_log [LOGN];
  logic [63:0] wd_log [LOGN];
  int          rd_n = 0;
  int          wr_n = 0;
  int          pulse_n = 0;
  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [63:0] pdata = '0;

  function automatic logic [63:0] mem_rd(input logic [51:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= (($urandom % 4) != 0);
    if (res_valid) pulse_n <= pulse_n + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wa_log[wr_n % LOGN] <= mem_req_addr;
        wd_log[wr_n % LOGN] <= mem_req_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_log[rd_n % LOGN] <= mem_req_addr;
        rd_n  <= rd_n + 1;
        pend  <= 1'b1;
        pcnt  <= 1;
        pdata <= mem_rd(mem_req_addr);
      end
    end
    if (pend) begin
      if (pcnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pdata;
        pend <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [39:0] next_page = 40'h1000;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      bad = bad + 1;
      $display("FAIL watchdog: global cycle limit reached act=%0d exp<=190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  e_fault;
  logic [2:0]  e_level;
  logic [51:0] e_paddr;
  int          e_nrd;
  logic [51:0] e_rd_addr [4];
  int          e_nwr;
  logic [51:0] e_wa [4];
  logic [63:0] e_wd [4];

  function automatic logic [8:0] va_index(input logic [47:0] va, input int lvl);
    case (lvl)
      0: return va[47:39];
      1: return va[38:30];
      2: return va[29:21];
      default: return va[20:12];
    endcase
  endfunction

  task automatic predict(input logic [47:0] va, input logic wr, input logic us);
    logic [39:0] tbl;
    logic [51:0] a;
    logic [63:0] e;
    logic [63:0] ne;
    tbl = root_base[51:12];
    e_nwr = 0;
    e_nrd = 0;
    e_paddr = '0;
    e_fault = 2'd0;
    e_level = 3'd4;
    for (int l = 0; l < 4; l++) begin
      a = {tbl, va_index(va, l), 3'b000};
      e = mem_rd(a);
      e_rd_addr[l] = a;
      e_nrd = l + 1;
      if (!e[0]) begin
        e_fault = 2'd1; e_level = 3'(l + 1); return;
      end
      if ((wr && !e[1]) || (us && !e[2])) begin
        e_fault = 2'd2; e_level = 3'(l + 1); return;
      end
      ne = e;
      ne[5] = 1'b1;
      if (l == 3 && wr) ne[6] = 1'b1;
      if (ne != e) begin
        e_wa[e_nwr] = a; e_wd[e_nwr] = ne; e_nwr++;
      end
      tbl = e[51:12];
      if (l == 3) e_paddr = {e[51:12], va[11:0]};
    end
  endtask

  // place a path for va; flags[l] supplies bits 11:0 of the level l+1 entry
  task automatic build_path(input logic [47:0] va, input logic [11:0] f0,
                            input logic [11:0] f1, input logic [11:0] f2,
                            input logic [11:0] f3);
    logic [39:0] tbl;
    logic [39:0] nxt;
    logic [11:0] f;
    tbl = root_base[51:12];
    for (int l = 0; l < 4; l++) begin
      f = (l == 0) ? f0 : (l == 1) ? f1 : (l == 2) ? f2 : f3;
      if (l == 3) nxt = {$urandom, 8'h00} | 40'(($urandom % 256));
      else begin nxt = next_page; next_page = next_page + 40'd1; end
      mem[{tbl, va_index(va, l), 3'b000}] = {12'h0, nxt, f};
      tbl = nxt;
    end
  endtask

  function automatic logic [11:0] rnd_flags();
    logic [11:0] f;
    f = 12'($urandom) & 12'h15A;  // random write-through, cache-off, global etc.
    f[0] = (($urandom % 14) != 0);
    f[1] = (($urandom % 5) != 0);
    f[2] = (($urandom % 5) != 0);
    f[5] = $urandom % 2;
    f[6] = $urandom % 2;
    return f;
  endfunction

  // ---------------- one walk ----------------
  task automatic run_walk(input logic [47:0] va, input logic wr, input logic us,
                          input bit hammer);
    int rs, ws, ps, cnt;
    logic [1:0]  a_fault;
    logic [2:0]  a_level;
    logic [51:0] a_paddr;
    predict(va, wr, us);
    @(negedge clk);
    rs = rd_n; ws = wr_n; ps = pulse_n;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready low after accept", 64'(req_ready), 64'd0);
    if (hammer) begin
      req_vaddr = ~va; req_write = ~wr; req_user = 1'b1;
    end else begin
      req_valid = 1'b0;
    end
    cnt = 0;
    while (!res_valid && cnt < 2000) begin
      if (hammer && cnt == 3)
        chk(req_ready == 1'b0, "R9", "ready low mid-walk", 64'(req_ready), 64'd0);
      @(negedge clk);
      cnt++;
    end
    if (cnt >= 2000) begin
      chk(1'b0, "R10", "walk timeout", 64'(cnt), 64'd2000);
      req_valid = 1'b0;
      return;
    end
    a_fault = res_fault; a_level = res_level; a_paddr = res_paddr;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(pulse_n - ps == 1, "R10", "one result pulse", 64'(pulse_n - ps), 64'd1);
    if (e_fault == 2'd1)
      chk(a_fault == 2'd1 && a_level == e_level, "R4", "not-present fault/level",
          {a_fault, 1'b0, a_level}, {e_fault, 1'b0, e_level});
    else if (e_fault == 2'd2)
      chk(a_fault == 2'd2 && a_level == e_level, wr ? "R5" : "R6", "protection fault/level",
          {a_fault, 1'b0, a_level}, {e_fault, 1'b0, e_level});
    else
      chk(a_fault == 2'd0 && a_level == 3'd4 && a_paddr == e_paddr, "R2", "physical address",
          64'(a_paddr), 64'(e_paddr));
    chk(rd_n - rs == e_nrd, "R3", "read count", 64'(rd_n - rs), 64'(e_nrd));
    for (int i = 0; i < e_nrd && i < rd_n - rs; i++)
      chk(rd_log[(rs + i) % LOGN] == e_rd_addr[i], "R3", "entry read address",
          64'(rd_log[(rs + i) % LOGN]), 64'(e_rd_addr[i]));
    chk(wr_n - ws == e_nwr, "R7", "write-back count", 64'(wr_n - ws), 64'(e_nwr));
    for (int i = 0; i < e_nwr && i < wr_n - ws; i++) begin
      chk(wa_log[(ws + i) % LOGN] == e_wa[i], "R7", "write-back address",
          64'(wa_log[(ws + i) % LOGN]), 64'(e_wa[i]));
      chk(wd_log[(ws + i) % LOGN] == e_wd[i], "R8", "write-back value",
          wd_log[(ws + i) % LOGN], e_wd[i]);
    end
    for (int i = ws; i < wr_n; i++) mem[wa_log[i % LOGN]] = wd_log[i % LOGN];
  endtask

  initial begin
    logic [47:0] va;
    void'($urandom(32'd4242));
    root_base = {40'h0000000100, 12'h000};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R1", "no result in reset", 64'(res_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1", "no mem request in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1", "idle after reset",
        {62'd0, req_ready, mem_req_valid}, 64'd2);

    // directed: flags already set, read -> no write-backs (R7)
    va = 48'h1234_5678_9ABC;
    build_path(va, 12'h067, 12'h067, 12'h067, 12'h167);
    run_walk(va, 1'b0, 1'b1, 1'b0);
    // directed: same path, write -> dirty already set, no writes (R8)
    run_walk(va, 1'b1, 1'b1, 1'b0);
    // directed: write with accessed set, dirty clear at leaf -> one leaf write (R8)
    va = 48'h7FFF_FFFF_F001;
    build_path(va, 12'h027, 12'h027, 12'h027, 12'h027);
    run_walk(va, 1'b1, 1'b0, 1'b0);
    // directed: all accessed clear, read -> four writes, dirty untouched (R7)
    va = 48'h0000_0000_0FFF;
    build_path(va, 12'h007, 12'h007, 12'h007, 12'h007);
    run_walk(va, 1'b0, 1'b0, 1'b0);
    // directed: not present at level 1 (R4)
    va = 48'h8000_0000_0000;
    build_path(va, 12'h006, 12'h007, 12'h007, 12'h007);
    run_walk(va, 1'b0, 1'b0, 1'b0);
    // directed: not present at level 4 (R4)
    va = 48'h4020_1008_0440;
    build_path(va, 12'h007, 12'h007, 12'h007, 12'h026);
    run_walk(va, 1'b1, 1'b0, 1'b0);
    // directed: write through read-only leaf (R5)
    va = 48'hABCD_EF01_2345;
    build_path(va, 12'h007, 12'h007, 12'h007, 12'h005);
    run_walk(va, 1'b1, 1'b0, 1'b0);
    // directed: user through supervisor entry at level 2 (R6)
    va = 48'h0102_0304_0506;
    build_path(va, 12'h007, 12'h003, 12'h007, 12'h007);
    run_walk(va, 1'b0, 1'b1, 1'b0);
    // directed: requests held during walk are ignored (R9)
    va = 48'h5555_AAAA_5555;
    build_path(va, 12'h007, 12'h007, 12'h007, 12'h007);
    run_walk(va, 1'b0, 1'b0, 1'b1);

    // random walks
    for (int t = 0; t < 300; t++) begin
      va = {$urandom, 16'($urandom)};
      build_path(va, rnd_flags(), rnd_flags(), rnd_flags(), rnd_flags());
      run_walk(va, 1'($urandom), 1'($urandom), (t % 7) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule